// File: doc/BRIEF.md
# Packed Float24 Vector Loader

This block accepts a stream of 32-bit words on a word-write port and groups them into four-component vectors of 24-bit floating-point values. In packed mode three consecutive words carry the four components, bit-packed with the last component first. In float32 mode four consecutive words each carry one IEEE single, and each is repacked to the 24-bit format (1 sign bit, 7-bit exponent biased by 63, 16-bit mantissa).

Each finished vector is written to an external vector memory through a one-cycle store strobe, together with its destination index. The index then advances by one. A configuration write loads a new index and selects the mode. It also discards any partly collected vector. A finished vector whose index lies above the memory's last entry is dropped: an error pulse is raised and the index stays where it is.

Top module: `packed_vec_loader`

## Requirements
- R1: After reset, vec_we_o and err_o are 0, next_idx_o is 0, packed mode is selected and no word is pending.
- R2: In packed mode a vector completes on its 3rd accepted word; in float32 mode (cfg_f32_i=1 at the last configuration write) it completes on its 4th. vec_we_o or err_o pulses for one cycle in the cycle after the completing word, and no strobe follows earlier words.
- R3: Packed decode, with vec_data_o holding x in bits [23:0], y in [47:24], z in [71:48] and w in [95:72]: w = word0[31:8], z = {word0[7:0], word1[31:16]}, y = {word1[15:0], word2[31:24]}, x = word2[23:0].
- R4: In float32 mode word i fills component 3-i, so word0 goes to w (bits [95:72]) and word3 to x (bits [23:0]).
- R5: A float32 value with sign s, biased exponent e (8 bits) and mantissa m (23 bits), where 65 <= e <= 191, becomes {s, e-64 (7 bits), m[22:7]}.
- R6: A float32 value with e <= 64 becomes {s, 23'b0}; with e >= 192 it becomes {s, 7'h7F, 16'h0000}.
- R7: A stored vector appears with vec_idx_o equal to the index in use, and next_idx_o then reads that index plus one.
- R8: A vector completed with an index above 95 is not stored (vec_we_o stays 0), err_o pulses for one cycle and next_idx_o keeps its value.
- R9: A configuration write loads the index from cfg_idx_i, latches the mode from cfg_f32_i and clears the pending-word count. A word write presented in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 7 | Start index loaded by a configuration write |
| cfg_f32_i | input | 1 | Mode loaded by a configuration write: 1 = float32, 0 = packed |
| word_wr_i | input | 1 | Word write strobe |
| word_i | input | 32 | Data word |
| vec_we_o | output | 1 | Vector store strobe |
| vec_idx_o | output | 7 | Index of the stored vector |
| vec_data_o | output | 96 | Stored vector, x in the low 24 bits |
| err_o | output | 1 | Pulse for a vector dropped because its index is out of range |
| next_idx_o | output | 7 | Index the next vector will use |

## Verification
The bench uses the default build: 7-bit index, last valid entry 95, a 24-bit component with a 7-bit exponent and a 16-bit mantissa. At this size every one of the 256 float32 exponent codes can be pushed through the converter in a single pass of 64 vectors. This covers both flush and saturate edges and the normal band between them. The index can also be stepped across the 95/96 boundary within a few vectors. Packed decode is checked against pseudo-random word streams, and partial vectors are cut off by configuration writes.

// File: rtl/pvl_pkg.sv
package pvl_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned COMP_W  = 24;
  localparam int unsigned N_COMP  = 4;
  localparam int unsigned VEC_W   = COMP_W * N_COMP;
  localparam int unsigned F32_EXP = 8;
  localparam int unsigned F32_MAN = 23;
  localparam int unsigned F32_BIAS = 127;

  typedef logic [COMP_W-1:0] comp_t;
  typedef logic [VEC_W-1:0]  vec_t;
endpackage

// File: rtl/pvl_f32_to_f24.sv
module pvl_f32_to_f24 #(
  parameter int unsigned EXP_W = 7,
  parameter int unsigned MAN_W = 16
) (
  input  logic [pvl_pkg::F32_EXP+MAN_W:0] f32_i,  // sign, exponent, top mantissa bits
  output logic [EXP_W+MAN_W:0]            f24_o
);
  import pvl_pkg::*;
  localparam int unsigned BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int unsigned SHIFT  = F32_BIAS - BIAS;
  localparam int unsigned EXPMAX = (1 << EXP_W) - 1;

  logic                sgn;
  logic [F32_EXP-1:0]  e_in;
  logic [MAN_W-1:0]    m_in;
  logic [F32_EXP:0]    e_ext;

  assign sgn   = f32_i[F32_EXP+MAN_W];
  assign e_in  = f32_i[F32_EXP+MAN_W-1:MAN_W];
  assign m_in  = f32_i[MAN_W-1:0];
  assign e_ext = {1'b0, e_in};

  always_comb begin
    if (e_ext <= (F32_EXP+1)'(SHIFT)) begin
      f24_o = {sgn, {(EXP_W+MAN_W){1'b0}}};
    end else if (e_ext > (F32_EXP+1)'(SHIFT + EXPMAX)) begin
      f24_o = {sgn, EXP_W'(EXPMAX), {MAN_W{1'b0}}};
    end else begin
      f24_o = {sgn, EXP_W'(e_ext - (F32_EXP+1)'(SHIFT)), m_in};
    end
  end
endmodule

// File: rtl/pvl_word_buf.sv
module pvl_word_buf #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned MAX_WORDS = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              clr_i,
  input  logic                              wr_i,
  input  logic [WORD_W-1:0]                 word_i,
  input  logic                              f32_i,
  output logic                              done_o,
  output logic [MAX_WORDS-1:0][WORD_W-1:0]  words_o
);
  localparam int unsigned CNT_W = $clog2(MAX_WORDS);
  localparam logic [CNT_W-1:0] LAST_F32 = CNT_W'(MAX_WORDS - 1);
  localparam logic [CNT_W-1:0] LAST_PK  = CNT_W'(MAX_WORDS - 2);

  logic [CNT_W-1:0]                  cnt_q;
  logic [MAX_WORDS-2:0][WORD_W-1:0]  hold_q;
  logic [CNT_W-1:0]                  last;
  logic                              acc;

  assign last   = f32_i ? LAST_F32 : LAST_PK;
  assign acc    = wr_i && !clr_i;
  assign done_o = acc && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (done_o)  cnt_q <= '0;
    else if (acc)     cnt_q <= cnt_q + 1'b1;
  end

  for (genvar i = 0; i < MAX_WORDS - 1; i++) begin : g_hold
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              hold_q[i] <= '0;
      else if (acc && cnt_q == CNT_W'(i))       hold_q[i] <= word_i;
    end
    assign words_o[i] = (cnt_q == CNT_W'(i)) ? word_i : hold_q[i];
  end
  assign words_o[MAX_WORDS-1] = word_i;

  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last);
  assert_cfg_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/pvl_index_ctrl.sv
module pvl_index_ctrl #(
  parameter int unsigned IDX_W   = 7,
  parameter int unsigned MAX_IDX = 95,
  parameter int unsigned VEC_W   = 96
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic              done_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic              we_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [VEC_W-1:0]  data_o,
  output logic              err_o,
  output logic [IDX_W-1:0]  next_idx_o
);
  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(MAX_IDX);

  logic [IDX_W-1:0] idx_q;
  logic             in_range;

  assign in_range   = idx_q <= LIMIT;
  assign next_idx_o = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      we_o   <= 1'b0;
      err_o  <= 1'b0;
      idx_o  <= '0;
      data_o <= '0;
    end else begin
      we_o  <= done_i && in_range;
      err_o <= done_i && !in_range;
      if (cfg_wr_i) begin
        idx_q <= cfg_idx_i;
      end else if (done_i && in_range) begin
        idx_q  <= idx_q + 1'b1;
        idx_o  <= idx_q;
        data_o <= vec_i;
      end
    end
  end

  assert_we_err_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_o && err_o));
  assert_err_holds_idx_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable(idx_q));
  assert_store_in_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> idx_o <= LIMIT);
  assert_idx_advance_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> next_idx_o == idx_o + 1'b1);
endmodule

// File: rtl/packed_vec_loader.sv
module packed_vec_loader #(
  parameter int unsigned IDX_W   = 7,
  parameter int unsigned MAX_IDX = 95,
  parameter int unsigned EXP_W   = 7,
  parameter int unsigned MAN_W   = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cfg_wr_i,
  input  logic [IDX_W-1:0]           cfg_idx_i,
  input  logic                       cfg_f32_i,
  input  logic                       word_wr_i,
  input  logic [pvl_pkg::WORD_W-1:0] word_i,
  output logic                       vec_we_o,
  output logic [IDX_W-1:0]           vec_idx_o,
  output logic [pvl_pkg::VEC_W-1:0]  vec_data_o,
  output logic                       err_o,
  output logic [IDX_W-1:0]           next_idx_o
);
  import pvl_pkg::*;
  localparam int unsigned CVT_IN = F32_EXP + MAN_W + 1;

  logic                             f32_q;
  logic                             done;
  logic [N_COMP-1:0][WORD_W-1:0]    words;
  logic [N_COMP-1:0][COMP_W-1:0]    cvt;
  vec_t                             vec_pk, vec_f32, vec_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       f32_q <= 1'b0;
    else if (cfg_wr_i) f32_q <= cfg_f32_i;
  end

  pvl_word_buf #(.WORD_W(WORD_W), .MAX_WORDS(N_COMP)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cfg_wr_i),
    .wr_i    (word_wr_i),
    .word_i  (word_i),
    .f32_i   (f32_q),
    .done_o  (done),
    .words_o (words)
  );

  // three packed words hold w,z,y,x from the top bit down
  assign vec_pk = {words[0], words[1], words[2]};

  for (genvar k = 0; k < N_COMP; k++) begin : g_cvt
    pvl_f32_to_f24 #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cvt (
      .f32_i (words[N_COMP-1-k][WORD_W-1 -: CVT_IN]),
      .f24_o (cvt[k])
    );
    assign vec_f32[k*COMP_W +: COMP_W] = cvt[k];
  end

  assign vec_sel = f32_q ? vec_f32 : vec_pk;

  pvl_index_ctrl #(.IDX_W(IDX_W), .MAX_IDX(MAX_IDX), .VEC_W(VEC_W)) u_idx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_wr_i   (cfg_wr_i),
    .cfg_idx_i  (cfg_idx_i),
    .done_i     (done),
    .vec_i      (vec_sel),
    .we_o       (vec_we_o),
    .idx_o      (vec_idx_o),
    .data_o     (vec_data_o),
    .err_o      (err_o),
    .next_idx_o (next_idx_o)
  );

  assert_flush_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_we_o && f32_q && vec_data_o[COMP_W-2 -: EXP_W] == '0)
      |-> vec_data_o[MAN_W-1:0] == '0);
endmodule

// File: tb/packed_vec_loader_tb.sv
`timescale 1ns/1ps
module packed_vec_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [6:0]  cfg_idx = '0;
  logic        cfg_f32 = 1'b0;
  logic        word_wr = 1'b0;
  logic [31:0] word = '0;
  logic        vec_we;
  logic [6:0]  vec_idx;
  logic [95:0] vec_data;
  logic        err;
  logic [6:0]  next_idx;

  int checks = 0;
  int errors = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #4 clk = ~clk;

  packed_vec_loader u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_idx_i(cfg_idx),
    .cfg_f32_i(cfg_f32), .word_wr_i(word_wr), .word_i(word),
    .vec_we_o(vec_we), .vec_idx_o(vec_idx), .vec_data_o(vec_data),
    .err_o(err), .next_idx_o(next_idx)
  );

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_word(input logic [31:0] w);
    @(negedge clk); word_wr = 1'b1; word = w;
    @(negedge clk); word_wr = 1'b0;
  endtask

  task automatic cfg(input logic [6:0] i, input logic f);
    @(negedge clk); cfg_wr = 1'b1; cfg_idx = i; cfg_f32 = f;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  function automatic logic [31:0] nxt();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  function automatic logic [23:0] ref_cvt(input logic [31:0] f);
    int e = int'(f[30:23]);
    if (e <= 64)       return {f[31], 23'b0};
    else if (e >= 192) return {f[31], 7'h7f, 16'h0};
    else               return {f[31], 7'(e - 64), f[22:7]};
  endfunction

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a, b, c, d;
    logic [95:0] exp;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 we", 96'(vec_we), 96'd0);
    chk("R1 err", 96'(err), 96'd0);
    chk("R1 idx", 96'(next_idx), 96'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // first packed vector straight out of reset: default mode is packed
    put_word(32'hA1B2C3D4); chk("R2 no strobe w1", 96'(vec_we), 96'd0);
    put_word(32'h11223344); chk("R2 no strobe w2", 96'(vec_we), 96'd0);
    put_word(32'h55667788); chk("R1 R2 packed done", 96'(vec_we), 96'd1);
    chk("R3 fixed", vec_data, {24'hA1B2C3, 24'hD41122, 24'h334455, 24'h667788});
    chk("R7 idx0", 96'(vec_idx), 96'd0);
    chk("R7 next1", 96'(next_idx), 96'd1);
    // R3 pseudo-random packed stream
    for (int v = 0; v < 30; v++) begin
      a = nxt(); b = nxt(); c = nxt();
      put_word(a); put_word(b); put_word(c);
      exp = {a[31:8], a[7:0], b[31:16], b[15:0], c[31:24], c[23:0]};
      chk("R3 data", vec_data, exp);
      chk("R7 idx", 96'(vec_idx), 96'(v + 1));
    end
    // R4 R5 R6 float32 sweep over all exponent codes
    cfg(7'd0, 1'b1);
    for (int v = 0; v < 64; v++) begin
      a = {1'(v), 8'(4*v+0), nxt()[22:0]};
      b = {1'(~v), 8'(4*v+1), nxt()[22:0]};
      c = {1'(v >> 1), 8'(4*v+2), nxt()[22:0]};
      d = {1'b1, 8'(4*v+3), nxt()[22:0]};
      put_word(a); put_word(b); put_word(c);
      chk("R2 f32 no strobe w3", 96'(vec_we), 96'd0);
      put_word(d);
      chk("R2 f32 done", 96'(vec_we), 96'd1);
      chk("R4 R5 R6 f32 data", vec_data, {ref_cvt(a), ref_cvt(b), ref_cvt(c), ref_cvt(d)});
      chk("R7 f32 idx", 96'(vec_idx), 96'(v));
    end
    // R8 boundary
    cfg(7'd95, 1'b0);
    put_word(1); put_word(2); put_word(3);
    chk("R8 idx95 stored", 96'(vec_we), 96'd1);
    chk("R8 idx95", 96'(vec_idx), 96'd95);
    chk("R7 next96", 96'(next_idx), 96'd96);
    put_word(4); put_word(5); put_word(6);
    chk("R8 no store", 96'(vec_we), 96'd0);
    chk("R8 err", 96'(err), 96'd1);
    chk("R8 idx held", 96'(next_idx), 96'd96);
    @(negedge clk);
    chk("R8 err one cycle", 96'(err), 96'd0);
    // R9 config clears partial vector
    put_word(32'hDEAD0000); put_word(32'hBEEF0000);
    cfg(7'd5, 1'b0);
    chk("R9 idx load", 96'(next_idx), 96'd5);
    put_word(32'h01020304); put_word(32'h05060708);
    chk("R9 no early strobe", 96'(vec_we), 96'd0);
    put_word(32'h090A0B0C);
    chk("R9 done after 3", 96'(vec_we), 96'd1);
    chk("R9 data", vec_data, {32'h01020304, 32'h05060708, 32'h090A0B0C});
    chk("R9 idx5", 96'(vec_idx), 96'd5);
    // R9 simultaneous word write ignored
    put_word(32'h77777777);
    @(negedge clk); cfg_wr = 1'b1; cfg_idx = 7'd9; cfg_f32 = 1'b0;
    word_wr = 1'b1; word = 32'hFFFFFFFF;
    @(negedge clk); cfg_wr = 1'b0; word_wr = 1'b0;
    put_word(32'hAAAAAAAA); put_word(32'hBBBBBBBB);
    chk("R9 word ignored", 96'(vec_we), 96'd0);
    put_word(32'hCCCCCCCC);
    chk("R9 after cfg", 96'(vec_we), 96'd1);
    chk("R9 data2", vec_data, {32'hAAAAAAAA, 32'hBBBBBBBB, 32'hCCCCCCCC});
    chk("R9 idx9", 96'(vec_idx), 96'd9);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule